// File: doc/BRIEF.md
# Keyed Window Watchdog

This block is a supervisory timer that runs from a slow, dedicated clock. A 17-bit counter climbs toward an overflow point chosen by a configuration byte. If the counter reaches that point, the block raises a one-cycle internal reset request. Software keeps the system alive by writing a fixed key value to the block. That write counts only when it lands inside the refresh window, which is the closing part of the overflow period.

The configuration byte is captured while reset is applied and then stays fixed. It sets five things: whether the counter runs, which of eight overflow periods applies, how wide the refresh window is, whether an early-warning pulse fires at three quarters of the period, and whether counting continues while the system sleeps.

Any write that is not an accepted refresh is treated as a fault. This covers a wrong value, and it also covers the right key written too early. A fault raises the reset request just as an overflow does. After each request the block clears itself back to its reset state and captures the configuration byte again.

Top module: `keyed_window_watchdog`

## Requirements
- R1: While reset is applied, rd_data_o reads 0x9A and irq_o and rst_req_o are low. cfg_byte_i is captured only during an external reset or the block's own reset cycle. Changes to cfg_byte_i at other times have no effect.
- R2: With bit 4 of the configuration set, the count advances by one on each clk edge. Bits 3:1 select the period P: values 0 to 7 give 2^6, 2^7, 2^8, 2^9, 2^11, 2^13, 2^14 and 2^16 clocks. rst_req_o rises P edges after reset release or after a refresh.
- R3: rst_req_o is high for exactly one cycle. On the next edge the block returns to its reset state: the count is zero, rd_data_o reads 0x9A, and the configuration is captured again. The next overflow follows P edges later.
- R4: Writing 0xAC while the window is open is a refresh. It clears the count, rd_data_o reads 0x1A from the following cycle, and the next overflow comes P edges after the write.
- R5: While counting is enabled, a write of any value other than 0xAC raises rst_req_o on the following cycle, whatever the window state.
- R6: Bits 6:5 set the window. 00 opens it when the count is at least P/2. 01 opens it when the count is at least P/4. 10 and 11 keep it open at all times. A 0xAC write while the count is below the opening point raises rst_req_o on the following cycle. The count is the number of edges since release or since the last refresh.
- R7: With bit 7 set, irq_o is a one-cycle pulse that goes high 3P/4 edges after release or refresh. With bit 7 clear, irq_o stays low.
- R8: With bit 4 clear, the counter does not run, rst_req_o and irq_o stay low, and writes are ignored, so rd_data_o stays 0x9A.
- R9: With bit 0 clear, a high sleep_i freezes the count, and counting resumes when sleep_i drops. With bit 0 set, sleep_i has no effect.
- R10: A 0xAC write at count P-1, the edge that would overflow, is a refresh. No reset request follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_i | input | 8 | Static configuration byte, captured during reset |
| sleep_i | input | 1 | System low-power state indicator |
| wr_en_i | input | 1 | Write strobe to the refresh register |
| wr_data_i | input | 8 | Value written to the refresh register |
| rd_data_o | output | 8 | Refresh register read value (0x9A or 0x1A) |
| irq_o | output | 1 | Early-warning interval pulse |
| rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
A refresh and an overflow can fall on the same edge. The bench provokes this by counting P-1 edges from release and writing the key on the edge where the counter sits at its last value. It judges the result from three things: rst_req_o stays low after that edge, rd_data_o switches to 0x1A, and the next reset request arrives a full P edges later. A refresh can also land just after the interval pulse. The bench checks that the pulse lasts one cycle and then reappears 3P/4 edges after the refresh.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int CFG_W = 8;

  // Configuration byte; field positions are fixed by the block's contract.
  typedef struct packed {
    logic       irq_en;    // bit 7
    logic [1:0] win_sel;   // bits 6:5
    logic       run;       // bit 4
    logic [2:0] ovf_sel;   // bits 3:1
    logic       stby_run;  // bit 0
  } wdt_cfg_t;

  typedef enum logic [1:0] {
    WIN_HALF    = 2'b00,
    WIN_QUARTER = 2'b01,
    WIN_ALL_A   = 2'b10,
    WIN_ALL_B   = 2'b11
  } win_t;

  // Exponent of the overflow period for a given selector.
  function automatic int unsigned ovf_exp(input logic [2:0] sel,
                                          input int unsigned base);
    case (sel)
      3'd0:    return base;
      3'd1:    return base + 1;
      3'd2:    return base + 2;
      3'd3:    return base + 3;
      3'd4:    return base + 5;
      3'd5:    return base + 7;
      3'd6:    return base + 8;
      default: return base + 10;
    endcase
  endfunction

endpackage

// File: rtl/wdt_limits.sv
module wdt_limits
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 17,
  parameter int MIN_EXP = 6
) (
  input  logic [2:0]       ovf_sel,
  input  logic [1:0]       win_sel,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] irq_cnt,
  output logic [CNT_W-1:0] win_start
);

  localparam logic [CNT_W:0] ONE_W = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W:0] period;
  logic [CNT_W:0] half_p;
  logic [CNT_W:0] quarter_p;
  logic [CNT_W:0] three_q;
  logic [CNT_W:0] last_w;
  logic [CNT_W:0] irq_w;

  always_comb begin
    period = '0;
    period[ovf_exp(ovf_sel, MIN_EXP)] = 1'b1;
  end

  assign half_p    = period >> 1;
  assign quarter_p = period >> 2;
  assign three_q   = half_p + quarter_p;
  assign last_w    = period - ONE_W;
  assign irq_w     = three_q - ONE_W;

  assign last_cnt = last_w[CNT_W-1:0];
  assign irq_cnt  = irq_w[CNT_W-1:0];

  always_comb begin
    case (win_t'(win_sel))
      WIN_HALF:    win_start = half_p[CNT_W-1:0];
      WIN_QUARTER: win_start = quarter_p[CNT_W-1:0];
      default:     win_start = '0;
    endcase
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  assign at_last = (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (clr)          cnt <= '0;
    else if (adv)     cnt <= at_last ? '0 : cnt + STEP;
  end

endmodule

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
  parameter int              DATA_W  = 8,
  parameter int              CNT_W   = 17,
  parameter logic [DATA_W-1:0] KEY     = 8'hAC,
  parameter logic [DATA_W-1:0] RD_INIT = 8'h9A,
  parameter logic [DATA_W-1:0] RD_DONE = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_int,
  input  logic              active,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  win_start,
  output logic              refresh,
  output logic              violation,
  output logic [DATA_W-1:0] rd_data
);

  logic key_hit;
  logic win_open;

  assign key_hit   = (wr_data == KEY);
  assign win_open  = (cnt >= win_start);
  assign refresh   = active & wr_en & key_hit & win_open;
  assign violation = active & wr_en & ~(key_hit & win_open);

  always_ff @(posedge clk) begin
    if (rst_int)      rd_data <= RD_INIT;
    else if (refresh) rd_data <= RD_DONE;
  end

endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_int,
  input  logic             enable,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] irq_cnt,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (rst_int) irq <= 1'b0;
    else         irq <= enable & adv & (cnt == irq_cnt);
  end

endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
  import wdt_pkg::*;
#(
  parameter int                CNT_W   = 17,
  parameter int                MIN_EXP = 6,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] KEY     = 8'hAC,
  parameter logic [DATA_W-1:0] RD_INIT = 8'h9A,
  parameter logic [DATA_W-1:0] RD_DONE = 8'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_byte_i,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  wdt_cfg_t         cfg_q;
  logic             rst_req_q;
  logic             rst_int;
  logic             live;
  logic             hold;
  logic             adv;
  logic             refresh;
  logic             violation;
  logic             overflow;
  logic             at_last;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] irq_cnt;
  logic [CNT_W-1:0] win_start;

  // Reset controller: the request itself becomes the next cycle's reset.
  assign rst_int = rst | rst_req_q;

  always_ff @(posedge clk) begin
    if (rst_int) cfg_q <= wdt_cfg_t'(cfg_byte_i);
  end

  assign live     = cfg_q.run & ~rst_req_q;
  assign hold     = sleep_i & ~cfg_q.stby_run;
  assign adv      = live & ~hold;
  assign overflow = adv & at_last & ~refresh;

  always_ff @(posedge clk) begin
    if (rst_int) rst_req_q <= 1'b0;
    else         rst_req_q <= overflow | violation;
  end

  wdt_limits #(
    .CNT_W   (CNT_W),
    .MIN_EXP (MIN_EXP)
  ) u_limits (
    .ovf_sel   (cfg_q.ovf_sel),
    .win_sel   (cfg_q.win_sel),
    .last_cnt  (last_cnt),
    .irq_cnt   (irq_cnt),
    .win_start (win_start)
  );

  wdt_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk      (clk),
    .clr      (rst_int | refresh),
    .adv      (adv),
    .last_cnt (last_cnt),
    .cnt      (cnt),
    .at_last  (at_last)
  );

  wdt_key_gate #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .KEY     (KEY),
    .RD_INIT (RD_INIT),
    .RD_DONE (RD_DONE)
  ) u_key (
    .clk       (clk),
    .rst_int   (rst_int),
    .active    (live),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .cnt       (cnt),
    .win_start (win_start),
    .refresh   (refresh),
    .violation (violation),
    .rd_data   (rd_data_o)
  );

  wdt_interval #(
    .CNT_W (CNT_W)
  ) u_interval (
    .clk     (clk),
    .rst_int (rst_int),
    .enable  (cfg_q.irq_en),
    .adv     (adv),
    .cnt     (cnt),
    .irq_cnt (irq_cnt),
    .irq     (irq_o)
  );

  assign rst_req_o = rst_req_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int         CNT_W   = 17,
  parameter logic [7:0] KEY     = 8'hAC,
  parameter logic [7:0] RD_DONE = 8'h1A
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       rd_data_o,
  input logic [7:0]       cfg_bits,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] win_start,
  input logic [CNT_W-1:0] last_cnt
);

  a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r5_bad_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i != KEY && cfg_bits[4] && !rst_req_o) |=> rst_req_o);

  a_r6_closed_window: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i == KEY && cfg_bits[4] && !rst_req_o && cnt_q < win_start)
    |=> rst_req_o);

  a_r4_refresh: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i == KEY && cfg_bits[4] && !rst_req_o && cnt_q >= win_start)
    |=> (rd_data_o == RD_DONE && !rst_req_o && cnt_q == '0));

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !cfg_bits[4] |-> (!rst_req_o && !irq_o));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !cfg_bits[0] && !wr_en_i && !rst_req_o) |=> $stable(cnt_q));

  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_cnt);

endmodule

bind keyed_window_watchdog wdt_checker #(
  .CNT_W   (CNT_W),
  .KEY     (KEY),
  .RD_DONE (RD_DONE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_i   (sleep_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .cfg_bits  (cfg_q),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .cnt_q     (cnt),
  .win_start (win_start),
  .last_cnt  (last_cnt)
);

// File: tb/keyed_window_watchdog_test.sv
module keyed_window_watchdog_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_byte = 8'h00;
  logic       sleep = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        irq;
  wire        rst_req;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  keyed_window_watchdog uut (
    .clk        (clk),
    .rst        (rst),
    .cfg_byte_i (cfg_byte),
    .sleep_i    (sleep),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .irq_o      (irq),
    .rst_req_o  (rst_req)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] wait_n;
    logic [7:0] data;
    logic       exp_rst;
    logic [7:0] exp_rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 8'd40, 8'hAC, 1'b0, 8'h1A, 4'd4},  // R4 50% window, inside
    '{8'h10, 8'd10, 8'hAC, 1'b1, 8'h9A, 4'd6},  // R6 too early
    '{8'h10, 8'd32, 8'hAC, 1'b0, 8'h1A, 4'd6},  // R6 first open count
    '{8'h10, 8'd31, 8'hAC, 1'b1, 8'h9A, 4'd6},  // R6 last closed count
    '{8'h10, 8'd40, 8'h55, 1'b1, 8'h9A, 4'd5},  // R5 wrong key in window
    '{8'h30, 8'd16, 8'hAC, 1'b0, 8'h1A, 4'd6},  // R6 75% window opens
    '{8'h30, 8'd15, 8'hAC, 1'b1, 8'h9A, 4'd6},  // R6 75% window closed
    '{8'h50, 8'd0,  8'hAC, 1'b0, 8'h1A, 4'd6},  // R6 full window at 0
    '{8'h70, 8'd3,  8'hAC, 1'b0, 8'h1A, 4'd6},  // R6 alternate full code
    '{8'h50, 8'd5,  8'h00, 1'b1, 8'h9A, 4'd5},  // R5 wrong key, full window
    '{8'h12, 8'd64, 8'hAC, 1'b0, 8'h1A, 4'd6},  // R6 longer period, open
    '{8'h12, 8'd63, 8'hAC, 1'b1, 8'h9A, 4'd6},  // R6 longer period, closed
    '{8'h00, 8'd5,  8'h55, 1'b0, 8'h9A, 4'd8},  // R8 stopped, bad key ignored
    '{8'h00, 8'd5,  8'hAC, 1'b0, 8'h9A, 4'd8}   // R8 stopped, key ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] c);
    @(negedge clk);
    cfg_byte = c;
    rst      = 1'b1;
    wr_en    = 1'b0;
    sleep    = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_rst(input int limit, output int n);
    n = 0;
    while (n < limit && rst_req !== 1'b1) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (n < limit && irq !== 1'b1) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    int hits;
    int exps [8] = '{6, 7, 8, 9, 11, 13, 14, 16};

    // R1 reset state
    do_reset(8'h10);
    chk("R1 rd after reset", rd_data, 8'h9A);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 req after reset", rst_req, 1'b0);

    // Vector table: single write after a number of counts
    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].cfg);
      step(int'(VECS[i].wait_n));
      wr(VECS[i].data);
      chk($sformatf("R%0d vec%0d req", VECS[i].req, i), rst_req, VECS[i].exp_rst);
      chk($sformatf("R%0d vec%0d rd", VECS[i].req, i), rd_data, VECS[i].exp_rd);
    end

    // R2 every overflow period, R3 pulse width
    for (int s = 0; s < 8; s++) begin
      do_reset({4'b0001, s[2:0], 1'b0});
      wait_rst(70000, n);
      chk($sformatf("R2 period sel%0d", s), n, 1 << exps[s]);
      step(1);
      chk("R3 req single cycle", rst_req, 1'b0);
    end

    // R1 capture only at reset, R3 return to reset state
    do_reset(8'h10);
    cfg_byte = 8'h12;
    wait_rst(1000, n);
    chk("R1 cfg change ignored", n, 64);
    step(1);
    chk("R3 req dropped", rst_req, 1'b0);
    chk("R3 rd back to init", rd_data, 8'h9A);
    wait_rst(1000, n);
    chk("R1 cfg recaptured", n, 128);

    // R4 refresh restarts the period
    do_reset(8'h10);
    step(40);
    wr(8'hAC);
    chk("R4 rd after refresh", rd_data, 8'h1A);
    wait_rst(1000, n);
    chk("R4 overflow after refresh", n, 64);

    // R10 refresh on the overflowing count
    do_reset(8'h10);
    step(63);
    wr(8'hAC);
    chk("R10 no req", rst_req, 1'b0);
    chk("R10 rd refreshed", rd_data, 8'h1A);
    wait_rst(1000, n);
    chk("R10 next overflow", n, 64);

    // R7 interval pulse, and again after a refresh
    do_reset(8'h90);
    wait_irq(1000, n);
    chk("R7 irq time", n, 48);
    step(1);
    chk("R7 irq single cycle", irq, 1'b0);
    wr(8'hAC);
    chk("R7 refresh after irq", rst_req, 1'b0);
    wait_irq(1000, n);
    chk("R7 irq after refresh", n, 48);

    // R7 pulse disabled
    do_reset(8'h10);
    hits = 0;
    for (int i = 0; i < 63; i++) begin
      step(1);
      if (irq === 1'b1) hits++;
    end
    chk("R7 irq disabled", hits, 0);

    // R8 counter stopped
    do_reset(8'h80);
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (irq === 1'b1 || rst_req === 1'b1) hits++;
    end
    chk("R8 no events while stopped", hits, 0);

    // R9 sleep freezes the count when standby counting is off
    do_reset(8'h10);
    step(10);
    sleep = 1'b1;
    step(100);
    chk("R9 no req while asleep", rst_req, 1'b0);
    sleep = 1'b0;
    wait_rst(1000, n);
    chk("R9 remaining counts", n, 54);

    // R9 sleep ignored when standby counting is on
    do_reset(8'h11);
    step(10);
    sleep = 1'b1;
    wait_rst(1000, n);
    chk("R9 standby keeps counting", n, 54);
    sleep = 1'b0;

    summary();
  end

endmodule